// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Serial DAC Register Front End

This block is the digital side of a two-channel current-output converter. A host writes it over a three-wire serial link made of an active-low select, a serial clock and a data line. Bits are shifted in while select is low. When select returns high, the word that was just shifted in is decoded. A 2-bit destination field chooses which channel's staging register takes the 16-bit code: none, channel A, channel B, or both at once. A second register rank per channel holds the code the converter actually sees. That rank follows the staging rank while an active-low load strobe is held low and freezes while it is high. This lets software stage both channels one after the other and then make them change together.

All serial and strobe pins are sampled into the system clock domain through two-flop synchronisers, and edges are found on the synchronised copies. An asynchronous active-low preset input forces every staging and output register to zero, or to midscale (bit 15 set) when the midscale-select pin is high. Applying the preset with that pin low is the power-on state. A select rise that comes after fewer than a full frame of bits still commits the zero-filled word and raises a one-cycle short-frame pulse. The serial pins are plain control pins with no valid/ready handshake, so the host can never be stalled. Host pacing must leave each serial pin level stable for at least three system clock cycles.

Top module: `dual_dac_frontend`

## Requirements
- R1: A frame is shifted most significant bit first. After 18 bits, bits [17:16] of the shift word are the destination code and bits [15:0] are the DAC code.
- R2: A bit is taken only on a synchronised rising edge of the serial clock while the synchronised select is low. Serial clock edges while select is high change no register and raise no short-frame pulse.
- R3: On a select rise, only the most recent 18 bits of the frame are used. Earlier bits are ignored, so a 24-bit frame with the valid word right-justified loads correctly.
- R4: Destination code 2'b00 writes no staging register, 2'b01 writes channel A, 2'b10 writes channel B, and 2'b11 writes the same code to both.
- R5: While the synchronised load strobe is low, each output register copies its staging register every cycle. While the strobe is high, the outputs hold.
- R6: Preset low asynchronously sets all four registers to 16'h0000 when the midscale select is 0, or to 16'h8000 when it is 1.
- R7: A select rise after fewer than 18 bits in the frame commits the word, zero-filled above the received bits, and drives the short-frame output high for exactly one cycle. A full or longer frame gives no pulse.
- R8: Preset wins over a pending select rise and over a low load strobe. A frame closed while preset is low leaves all registers at the preset value.
- R9: With the load strobe high, channels written one after another leave the outputs unchanged. A later load pulse moves both outputs to their new codes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial and strobe pins |
| preset_n | input | 1 | Asynchronous active-low preset of all code registers |
| mid_sel | input | 1 | Preset value select: 0 gives zero, 1 gives midscale |
| ser_sel_n | input | 1 | Serial select, active low; a rise closes the frame |
| ser_clk | input | 1 | Serial bit clock, rising edge samples data |
| ser_dat | input | 1 | Serial data, most significant bit first |
| load_n | input | 1 | Active-low, level-sensitive output register load |
| dac_a | output | 16 | Channel A output register code |
| dac_b | output | 16 | Channel B output register code |
| short_frame | output | 1 | One-cycle pulse on a frame shorter than 18 bits |

## Verification
The hardest case to reach from the ports is a frame closed while preset is low. The select rise must be present when preset asserts, and the load strobe must be low so that any commit that slipped through would show at the outputs. The stimulus shifts a full broadcast frame with the strobe low. It asserts preset before raising select, then checks both outputs at the preset value during preset and after its release. A sweep over every frame length from 1 to 24 bits, run for each destination code, covers the short-frame boundary and the discarding of leading bits.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    DST_NONE = 2'b00,
    DST_A    = 2'b01,
    DST_B    = 2'b10,
    DST_BOTH = 2'b11
  } dest_e;

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stg[g] <= RST_VAL;
        else         stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stg[g] <= RST_VAL;
        else         stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter #(
  parameter int FRAME_W = 18
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               sel_n_s,
  input  logic               sclk_s,
  input  logic               sdat_s,
  output logic               commit,
  output logic [FRAME_W-1:0] word,
  output logic               short_pulse
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

  logic               sel_d;
  logic               sclk_d;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;
  logic               sel_rise;
  logic               sel_fall;
  logic               bit_stb;

  assign sel_rise = sel_n_s & ~sel_d;
  assign sel_fall = ~sel_n_s & sel_d;
  assign bit_stb  = ~sel_n_s & sclk_s & ~sclk_d;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sel_d  <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      sel_d  <= sel_n_s;
      sclk_d <= sclk_s;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (sel_fall) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (bit_stb) begin
      shreg   <= {shreg[FRAME_W-2:0], sdat_s};
      if (bit_cnt != FULL_CNT) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) short_pulse <= 1'b0;
    else         short_pulse <= sel_rise && (bit_cnt < FULL_CNT);
  end

  assign commit = sel_rise;
  assign word   = shreg;

  AST_SHORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!arst_n)
    short_pulse |=> !short_pulse); // R7

  AST_NO_SHIFT_SEL_HIGH: assert property (@(posedge clk) disable iff (!arst_n)
    sel_n_s |=> $stable(shreg)); // R2

endmodule

// File: rtl/dacfe_channel.sv
module dacfe_channel #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [DATA_W-1:0] preset_val,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load_en,
  output logic [DATA_W-1:0] dac_q
);
  logic [DATA_W-1:0] in_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)  in_q <= preset_val;
    else if (we)  in_q <= wdata;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      dac_q <= preset_val;
    else if (load_en) dac_q <= in_q;
  end

  AST_HOLD_LOAD_HIGH: assert property (@(posedge clk) disable iff (!arst_n)
    !load_en |=> $stable(dac_q)); // R5

  AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!arst_n)
    load_en |=> dac_q == $past(in_q)); // R5

  AST_NO_WRITE_KEEP: assert property (@(posedge clk) disable iff (!arst_n)
    !we |=> $stable(in_q)); // R4

endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              preset_n,
  input  logic              mid_sel,
  input  logic              ser_sel_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              load_n,
  output logic [DATA_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_b,
  output logic              short_frame
);
  import dacfe_pkg::*;

  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int N_CH    = 2;
  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  logic [3:0]         pins_s;
  logic               sel_n_s, sclk_s, sdat_s, load_n_s;
  logic               commit;
  logic [FRAME_W-1:0] word;
  logic [DATA_W-1:0]  preset_val;
  dest_e              dest;
  logic [N_CH-1:0]    we;
  logic [DATA_W-1:0]  dac_q [N_CH];

  assign preset_val = mid_sel ? MID_CODE : '0;

  dacfe_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk    (clk),
    .arst_n (preset_n),
    .d      ({ser_sel_n, ser_clk, ser_dat, load_n}),
    .q      (pins_s)
  );
  assign {sel_n_s, sclk_s, sdat_s, load_n_s} = pins_s;

  dacfe_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk         (clk),
    .arst_n      (preset_n),
    .sel_n_s     (sel_n_s),
    .sclk_s      (sclk_s),
    .sdat_s      (sdat_s),
    .commit      (commit),
    .word        (word),
    .short_pulse (short_frame)
  );

  assign dest = dest_e'(word[FRAME_W-1 -: ADDR_W]);

  always_comb begin
    we = '0;
    if (commit) begin
      case (dest)
        DST_A:    we = 2'b01;
        DST_B:    we = 2'b10;
        DST_BOTH: we = 2'b11;
        default:  we = 2'b00;
      endcase
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dacfe_channel #(.DATA_W(DATA_W)) u_ch (
      .clk        (clk),
      .arst_n     (preset_n),
      .preset_val (preset_val),
      .we         (we[c]),
      .wdata      (word[DATA_W-1:0]),
      .load_en    (~load_n_s),
      .dac_q      (dac_q[c])
    );
  end

  assign dac_a = dac_q[0];
  assign dac_b = dac_q[1];

  AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (!preset_n)
    load_n_s |=> ($stable(dac_a) && $stable(dac_b))); // R9

endmodule

// File: tb/dual_dac_frontend_tb.sv
module dual_dac_frontend_tb;
  logic        clk = 1'b0;
  logic        preset_n = 1'b0;
  logic        mid_sel = 1'b0;
  logic        ser_sel_n = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_dat = 1'b0;
  logic        load_n = 1'b1;
  logic [15:0] dac_a, dac_b;
  logic        short_frame;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int wide = 0;
  bit done = 0;
  logic prev_short = 1'b0;

  logic [15:0] in_a, in_b, exp_a, exp_b;

  always #5 clk = ~clk;

  dual_dac_frontend u_dut (
    .clk(clk), .preset_n(preset_n), .mid_sel(mid_sel),
    .ser_sel_n(ser_sel_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .load_n(load_n), .dac_a(dac_a), .dac_b(dac_b), .short_frame(short_frame)
  );

  always @(negedge clk) begin
    if (short_frame) pulses++;
    if (short_frame && prev_short) wide++;
    prev_short = short_frame;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    @(negedge clk);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input int n, input logic [31:0] val);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = val[i];
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
    end
  endtask

  // n bits of val, MSB first; updates staging model
  task automatic send_frame(input int n, input logic [31:0] val);
    logic [17:0] w;
    ser_sel_n = 1'b0;
    wait_clk(5);
    shift_bits(n, val);
    wait_clk(4);
    ser_sel_n = 1'b1;
    wait_clk(6);
    w = '0;
    for (int i = n - 1; i >= 0; i--) w = {w[16:0], val[i]};
    if (w[16]) in_a = w[15:0];
    if (w[17]) in_b = w[15:0];
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    wait_clk(6);
    load_n = 1'b1;
    wait_clk(5);
    exp_a = in_a;
    exp_b = in_b;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p0;
    logic [15:0] pat;
    in_a = '0; in_b = '0; exp_a = '0; exp_b = '0;
    wait_clk(3);
    // R6 power-on / zero preset
    check("R6 zero preset A", dac_a, 16'h0000);
    check("R6 zero preset B", dac_b, 16'h0000);
    preset_n = 1'b1;
    wait_clk(4);

    // R1 R4 R9: sweep destinations and codes, load held high during writes
    for (int d = 0; d < 4; d++) begin
      for (int k = 0; k < 8; k++) begin
        pat = 16'((k * 16'h2F1D) ^ 16'hA5C3 ^ (d << 12));
        send_frame(18, {14'd0, 2'(d), pat});
        check($sformatf("R9 hold A d=%0d", d), dac_a, exp_a);
        check($sformatf("R9 hold B d=%0d", d), dac_b, exp_b);
        pulse_load();
        check($sformatf("R4 R1 load A d=%0d", d), dac_a, exp_a);
        check($sformatf("R4 R1 load B d=%0d", d), dac_b, exp_b);
      end
    end

    // R9: write A then B separately, both change on one load pulse
    send_frame(18, {14'd0, 2'b01, 16'h1357});
    send_frame(18, {14'd0, 2'b10, 16'hFEDC});
    check("R9 staged A unchanged", dac_a, exp_a);
    check("R9 staged B unchanged", dac_b, exp_b);
    pulse_load();
    check("R9 joint A", dac_a, 16'h1357);
    check("R9 joint B", dac_b, 16'hFEDC);

    // R3 R7: every length 1..24 for each destination code
    for (int n = 1; n <= 24; n++) begin
      for (int d = 0; d < 4; d++) begin
        logic [31:0] v;
        v = (32'h00C3_5A96 ^ (n * 32'h0001_3579)) & ((32'd1 << n) - 1);
        if (n >= 18) v[17:16] = 2'(d);
        p0 = pulses;
        send_frame(n, v);
        check($sformatf("R7 short flag n=%0d", n), 32'(pulses - p0), (n < 18) ? 32'd1 : 32'd0);
        pulse_load();
        check($sformatf("R3 R7 A n=%0d", n), dac_a, exp_a);
        check($sformatf("R3 R7 B n=%0d", n), dac_b, exp_b);
      end
    end
    check("R7 pulse one cycle", 32'(wide), 32'd0);

    // R5: load held low, outputs follow new writes directly
    load_n = 1'b0;
    wait_clk(5);
    send_frame(18, {14'd0, 2'b11, 16'h4C4C});
    check("R5 transparent A", dac_a, 16'h4C4C);
    check("R5 transparent B", dac_b, 16'h4C4C);
    // R2: serial clock toggles with select high are ignored
    p0 = pulses;
    for (int i = 0; i < 6; i++) begin
      ser_dat = i[0];
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
    end
    wait_clk(5);
    check("R2 no change A", dac_a, 16'h4C4C);
    check("R2 no change B", dac_b, 16'h4C4C);
    check("R2 no short pulse", 32'(pulses - p0), 32'd0);

    // R6 midscale preset
    mid_sel = 1'b1;
    preset_n = 1'b0;
    wait_clk(2);
    check("R6 mid preset A", dac_a, 16'h8000);
    check("R6 mid preset B", dac_b, 16'h8000);
    preset_n = 1'b1;
    wait_clk(5);
    check("R6 mid after release A", dac_a, 16'h8000);

    // R8: frame closed during preset is lost, load low does not matter
    ser_sel_n = 1'b0;
    wait_clk(5);
    shift_bits(18, {14'd0, 2'b11, 16'h0F0F});
    wait_clk(3);
    preset_n = 1'b0;
    wait_clk(2);
    ser_sel_n = 1'b1;
    wait_clk(6);
    check("R8 preset wins A", dac_a, 16'h8000);
    check("R8 preset wins B", dac_b, 16'h8000);
    preset_n = 1'b1;
    wait_clk(8);
    check("R8 after release A", dac_a, 16'h8000);
    check("R8 after release B", dac_b, 16'h8000);
    load_n = 1'b1;

    // R6 back to zero preset
    mid_sel = 1'b0;
    preset_n = 1'b0;
    wait_clk(2);
    check("R6 zero again A", dac_a, 16'h0000);
    check("R6 zero again B", dac_b, 16'h0000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule